// File: doc/BRIEF.md
# Ordered Address/Data Replay Writer

This block keeps a small table of entries, each a memory word index paired with a data word. Software or a test controller fills the table through a narrow load port while the block is idle. A start pulse then replays the entries one after another onto a write path made of two valid/ready channels. One channel carries the byte address and the other carries the data. When the last entry has been taken on both channels, the block raises `done`.

The replay order is exactly the table order, and the addresses in the table need not be sorted. When two entries name the same word, the one that comes later in the table is written last, so its value is what the memory ends up holding. Memory words that no entry names are never touched. The number of entries to replay is given on `run_count` and is sampled when `start` is accepted.

Top module: `pattern_write_seq`

## Requirements
- R1: After reset, `done`, `cmd_valid` and `wd_valid` are all low.
- R2: A load writes slot `load_idx` with `load_addr`/`load_data` only while no replay is running; a load presented during a replay leaves the table unchanged.
- R3: Entries are issued strictly in slot order 0, 1, 2 and onward. Each entry's `cmd_addr` is its word index multiplied by DATA_W/8 (word index shifted left by log2(DATA_W/8)), and its `wd_data` is the data stored in the same slot.
- R4: On each channel, a raised valid stays high, with address or data unchanged, until ready is seen. The two channels are accepted independently, and each carries exactly one transfer per entry.
- R5: `done` rises in the cycle after the last entry has been accepted on both channels. From then until the next start, neither channel asserts valid.
- R6: `run_count` is captured when a start is accepted and is clamped to DEPTH. A count of zero raises `done` one cycle after start, with no transfers.
- R7: A start pulse during a running replay is ignored, and the running count and order stay as they were.
- R8: When addresses repeat, the later entry's data is the final memory content. Words that no entry names keep their previous value.
- R9: With 64-bit data, an entry whose word index is 5 produces the byte address 0x28.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| load_en | input | 1 | Write one table slot |
| load_idx | input | log2(DEPTH) | Slot to write |
| load_addr | input | WADDR_W | Word index stored in the slot |
| load_data | input | DATA_W | Data stored in the slot |
| run_count | input | log2(DEPTH+1) | Number of entries to replay |
| start | input | 1 | Begin a replay from slot 0 |
| cmd_valid | output | 1 | Address channel valid |
| cmd_ready | input | 1 | Address channel ready |
| cmd_addr | output | WADDR_W+log2(DATA_W/8) | Byte address of the current entry |
| wd_valid | output | 1 | Data channel valid |
| wd_ready | input | 1 | Data channel ready |
| wd_data | output | DATA_W | Data of the current entry |
| done | output | 1 | Replay complete |

## Verification
The hold checks assume that the memory side never withdraws a transfer. The bench drives both ready lines only from fixed cycle-count patterns, so a transfer completes exactly when valid and ready are high together. The checks also assume that the table slot being issued cannot change under them. The bench only loads during a replay in order to show that such loads are dropped, and it confirms at the ports that the dropped value never appears. Start pulses are one cycle wide, and `run_count` is held stable around each start.

// File: rtl/pws_pkg.sv
// Package: shared state encoding for the replay writer.
// Assumes: nothing beyond a two-bit state field.
package pws_pkg;
    typedef enum logic [1:0] {
        SQ_IDLE = 2'd0,
        SQ_RUN  = 2'd1,
        SQ_FIN  = 2'd2
    } sq_state_e;
endpackage

// File: rtl/pws_table.sv
// Module: pws_table
// Holds DEPTH (word index, data) slots with one write port and one
// combinational read port. The contents are not reset.
// Assumes: the caller gates writes (no writes while a replay runs).
module pws_table #(
    parameter int DATA_W  = 32,
    parameter int WADDR_W = 7,
    parameter int DEPTH   = 64,
    localparam int IDX_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic               clk,
    input  logic               wr_en,
    input  logic [IDX_W-1:0]   wr_idx,
    input  logic [WADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0]  wr_data,
    input  logic [IDX_W-1:0]   rd_idx,
    output logic [WADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0]  rd_data
);
    logic [WADDR_W-1:0] slot_addr [DEPTH];
    logic [DATA_W-1:0]  slot_data [DEPTH];

    // Store one slot when a gated load arrives.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            slot_addr[wr_idx] <= wr_addr;
            slot_data[wr_idx] <= wr_data;
        end
    end

    // Present the slot selected by the sequencer.
    always_comb begin
        rd_addr = slot_addr[rd_idx];
        rd_data = slot_data[rd_idx];
    end
endmodule

// File: rtl/pws_chan.sv
// Module: pws_chan
// Tracks one valid/ready channel for the current entry: it raises valid
// while the entry is active and not yet taken, and it remembers the take
// until all channels finish and the entry advances.
// Assumes: advance is raised only when every channel is complete.
module pws_chan (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    input  logic advance,
    input  logic ready,
    output logic valid,
    output logic complete
);
    logic taken;

    // Remember that this entry was accepted on this channel.
    always_ff @(posedge clk) begin
        if (!rst_n)               taken <= 1'b0;
        else if (advance)         taken <= 1'b0;
        else if (valid && ready)  taken <= 1'b1;
    end

    // Offer the entry and report when it is taken.
    always_comb begin
        valid    = active && !taken;
        complete = taken || (valid && ready);
    end

    // R4: a raised valid is not withdrawn before ready.
    a_r4_valid_held: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && !ready) |=> valid);
    // R4: at most one transfer per entry on this channel.
    a_r4_single_take: assert property (@(posedge clk) disable iff (!rst_n)
        (taken && !advance) |-> !valid);
endmodule

// File: rtl/pws_seq.sv
// Module: pws_seq
// Walks slot indices from 0 to count-1. It latches a clamped count at
// start, advances one slot per completed entry, and parks in a finished
// state until the next start.
// Assumes: step is only raised while active.
module pws_seq
    import pws_pkg::*;
#(
    parameter int DEPTH   = 64,
    localparam int IDX_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W  = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CNT_W-1:0] req_count,
    input  logic             step,
    output logic             active,
    output logic             fin,
    output logic [IDX_W-1:0] idx
);
    sq_state_e        state;
    logic [IDX_W-1:0] last;
    logic [CNT_W-1:0] eff_count;

    // Clamp the requested count to the table depth.
    always_comb begin
        eff_count = (req_count > CNT_W'(DEPTH)) ? CNT_W'(DEPTH) : req_count;
    end

    // Run the idle/run/finished walk over the slot index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= SQ_IDLE;
            idx   <= '0;
            last  <= '0;
        end else begin
            case (state)
                SQ_RUN: begin
                    if (step) begin
                        if (idx == last) state <= SQ_FIN;
                        else             idx   <= idx + 1'b1;
                    end
                end
                default: begin
                    if (start) begin
                        idx <= '0;
                        if (eff_count == '0) begin
                            state <= SQ_FIN;
                        end else begin
                            state <= SQ_RUN;
                            last  <= IDX_W'(eff_count - 1'b1);
                        end
                    end
                end
            endcase
        end
    end

    // Decode the state for the rest of the block.
    always_comb begin
        active = (state == SQ_RUN);
        fin    = (state == SQ_FIN);
    end

    // R6: the index never runs past the latched last slot.
    a_r6_idx_bound: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> (idx <= last));
    // R3: a completed non-final entry moves to the next slot.
    a_r3_next_slot: assert property (@(posedge clk) disable iff (!rst_n)
        (active && step && idx != last) |=> (active && idx == $past(idx) + 1'b1));
    // R7: a start during a run leaves the index in place when no step occurs.
    a_r7_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (active && start && !step) |=> (active && $stable(idx)));
endmodule

// File: rtl/pattern_write_seq.sv
// Module: pattern_write_seq
// Top of the replay writer: it holds the slot table, gates loads to idle
// time, and replays slots in order over separate address and data
// valid/ready channels, then signals done.
// Assumes: DATA_W is a power-of-two multiple of 8, and the memory side
// never retracts a transfer once valid and ready coincide.
module pattern_write_seq #(
    parameter int DATA_W  = 32,
    parameter int WADDR_W = 7,
    parameter int DEPTH   = 64,
    localparam int IDX_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W  = $clog2(DEPTH + 1),
    localparam int BYTE_SH = $clog2(DATA_W / 8),
    localparam int BADDR_W = WADDR_W + BYTE_SH
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load_en,
    input  logic [IDX_W-1:0]   load_idx,
    input  logic [WADDR_W-1:0] load_addr,
    input  logic [DATA_W-1:0]  load_data,
    input  logic [CNT_W-1:0]   run_count,
    input  logic               start,
    output logic               cmd_valid,
    input  logic               cmd_ready,
    output logic [BADDR_W-1:0] cmd_addr,
    output logic               wd_valid,
    input  logic               wd_ready,
    output logic [DATA_W-1:0]  wd_data,
    output logic               done
);
    logic               active;
    logic               fin;
    logic               step;
    logic               tab_wr;
    logic [IDX_W-1:0]   cur_idx;
    logic [WADDR_W-1:0] cur_word;
    logic               cmd_cpl;
    logic               wd_cpl;

    // Accept loads only while no replay is running.
    always_comb begin
        tab_wr = load_en && !active && (int'(load_idx) < DEPTH);
    end

    pws_table #(
        .DATA_W (DATA_W),
        .WADDR_W(WADDR_W),
        .DEPTH  (DEPTH)
    ) table_i (
        .clk    (clk),
        .wr_en  (tab_wr),
        .wr_idx (load_idx),
        .wr_addr(load_addr),
        .wr_data(load_data),
        .rd_idx (cur_idx),
        .rd_addr(cur_word),
        .rd_data(wd_data)
    );

    pws_seq #(
        .DEPTH(DEPTH)
    ) seq_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .req_count(run_count),
        .step     (step),
        .active   (active),
        .fin      (fin),
        .idx      (cur_idx)
    );

    pws_chan cmd_ch_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .active  (active),
        .advance (step),
        .ready   (cmd_ready),
        .valid   (cmd_valid),
        .complete(cmd_cpl)
    );

    pws_chan wd_ch_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .active  (active),
        .advance (step),
        .ready   (wd_ready),
        .valid   (wd_valid),
        .complete(wd_cpl)
    );

    // Advance when both channels have taken the entry; scale word to bytes.
    always_comb begin
        step     = active && cmd_cpl && wd_cpl;
        cmd_addr = BADDR_W'(cur_word) << BYTE_SH;
        done     = fin;
    end

    // R4: the address holds while the command waits for ready.
    a_r4_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_addr)));
    // R4: the data holds while the data transfer waits for ready.
    a_r4_data_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (wd_valid && !wd_ready) |=> (wd_valid && $stable(wd_data)));
    // R5: nothing is offered once done is high.
    a_r5_quiet_done: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!cmd_valid && !wd_valid));
    // R5: done stays up until a start arrives.
    a_r5_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> done);
endmodule

// File: tb/pattern_write_seq_tb.sv
module pattern_write_seq_tb_top;
    localparam int DW  = 32;
    localparam int AW  = 7;
    localparam int DEP = 64;
    localparam int MEMW = 128;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic        load_en = 1'b0;
    logic [5:0]  load_idx = '0;
    logic [6:0]  load_addr = '0;
    logic [31:0] load_data = '0;
    logic [6:0]  run_count = '0;
    logic        start = 1'b0;
    logic        cmd_valid, wd_valid, done;
    logic        cmd_ready = 1'b1, wd_ready = 1'b1;
    logic [8:0]  cmd_addr;
    logic [31:0] wd_data;

    pattern_write_seq #(.DATA_W(DW), .WADDR_W(AW), .DEPTH(DEP)) dut_i (
        .clk(clk), .rst_n(rst_n), .load_en(load_en), .load_idx(load_idx),
        .load_addr(load_addr), .load_data(load_data), .run_count(run_count),
        .start(start), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_addr(cmd_addr), .wd_valid(wd_valid), .wd_ready(wd_ready),
        .wd_data(wd_data), .done(done)
    );

    // 64-bit instance for the byte-offset check
    logic        l64_en = 1'b0;
    logic [2:0]  l64_idx = '0;
    logic [3:0]  l64_addr = '0;
    logic [63:0] l64_data = '0;
    logic [3:0]  c64 = '0;
    logic        s64 = 1'b0;
    logic        v64c, v64d, d64;
    logic [6:0]  a64;
    logic [63:0] w64;

    pattern_write_seq #(.DATA_W(64), .WADDR_W(4), .DEPTH(8)) dut64_i (
        .clk(clk), .rst_n(rst_n), .load_en(l64_en), .load_idx(l64_idx),
        .load_addr(l64_addr), .load_data(l64_data), .run_count(c64),
        .start(s64), .cmd_valid(v64c), .cmd_ready(1'b1), .cmd_addr(a64),
        .wd_valid(v64d), .wd_ready(1'b1), .wd_data(w64), .done(d64)
    );

    int total = 0;
    int bad = 0;
    int throttle = 0;
    int cyc = 0;

    logic [6:0]  exp_addr [DEP];
    logic [31:0] exp_data [DEP];
    logic [31:0] mem [MEMW];
    logic [31:0] want [MEMW];
    logic [8:0]  cap_a [256];
    logic [31:0] cap_d [256];
    int n_cmd = 0;
    int n_wd = 0;

    // ready patterns, changed away from the active edge
    always @(negedge clk) begin
        cyc <= cyc + 1;
        cmd_ready <= (throttle != 0) ? ((cyc % 3) != 0) : 1'b1;
        wd_ready  <= (throttle != 0) ? ((cyc % 5) != 2) : 1'b1;
    end

    // capture accepted transfers per channel
    always @(posedge clk) begin
        if (rst_n && cmd_valid && cmd_ready) begin
            if (n_cmd < 256) cap_a[n_cmd] = cmd_addr;
            n_cmd = n_cmd + 1;
        end
        if (rst_n && wd_valid && wd_ready) begin
            if (n_wd < 256) cap_d[n_wd] = wd_data;
            n_wd = n_wd + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    task automatic load(input int i, input logic [6:0] a, input logic [31:0] d, input bit track);
        @(negedge clk);
        load_en = 1'b1; load_idx = 6'(i); load_addr = a; load_data = d;
        @(negedge clk);
        load_en = 1'b0;
        if (track) begin
            exp_addr[i] = a;
            exp_data[i] = d;
        end
    endtask

    task automatic kick(input int cnt);
        @(negedge clk);
        n_cmd = 0; n_wd = 0;
        run_count = 7'(cnt); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done(input string req);
        int k = 0;
        while (!done && k < 5000) begin
            @(negedge clk);
            k++;
        end
        chk(done, req, 64'(done), 64'd1);
    endtask

    // compare captured stream to the table and replay it into memory
    task automatic verify_run(input int cnt, input string req);
        chk(n_cmd == cnt, req, 64'(n_cmd), 64'(cnt));
        chk(n_wd == cnt, req, 64'(n_wd), 64'(cnt));
        for (int k = 0; k < cnt && k < n_cmd && k < n_wd; k++) begin
            chk(cap_a[k] == {2'b00, exp_addr[k]} * 9'd4, "R3 addr", 64'(cap_a[k]), 64'({2'b00, exp_addr[k]} * 9'd4));
            chk(cap_d[k] == exp_data[k], "R3 data", 64'(cap_d[k]), 64'(exp_data[k]));
            mem[cap_a[k] >> 2] = cap_d[k];
        end
    endtask

    task automatic clear_mem();
        for (int m = 0; m < MEMW; m++) begin
            mem[m] = '0;
            want[m] = '0;
        end
    endtask

    task automatic cmp_mem(input string req);
        int errs = 0;
        for (int m = 0; m < MEMW; m++) if (mem[m] !== want[m]) errs++;
        chk(errs == 0, req, 64'(errs), 64'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(!done && !cmd_valid && !wd_valid, "R1", {61'd0, done, cmd_valid, wd_valid}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!done && !cmd_valid && !wd_valid, "R1", {61'd0, done, cmd_valid, wd_valid}, 64'd0);

        // R2, R3, R5: sequential addresses, free-flowing ready
        clear_mem();
        for (int i = 0; i < DEP; i++) load(i, 7'(i), 32'h1234 + 32'(i) * 32'h01010101, 1'b1);
        for (int i = 0; i < DEP; i++) want[i] = 32'h1234 + 32'(i) * 32'h01010101;
        kick(64);
        wait_done("R5 sequential");
        verify_run(64, "R3 sequential count");
        cmp_mem("R8 sequential memory");
        // R5: quiet after done
        repeat (6) begin
            @(negedge clk);
            chk(!cmd_valid && !wd_valid && done, "R5 quiet", {62'd0, cmd_valid, wd_valid}, 64'd0);
        end
        chk(n_cmd == 64, "R5 no extra", 64'(n_cmd), 64'd64);

        // R4, R7, R2: permuted addresses, throttled ready, start and load mid-run
        clear_mem();
        throttle = 1;
        for (int i = 0; i < DEP; i++) load(i, 7'((i * 37 + 11) % 128), 32'hA5A50000 ^ 32'(i * 77), 1'b1);
        for (int i = 0; i < DEP; i++) want[(i * 37 + 11) % 128] = 32'hA5A50000 ^ 32'(i * 77);
        kick(64);
        repeat (10) @(negedge clk);
        run_count = 7'd5; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        load(63, 7'd0, 32'hDEADDEAD, 1'b0);
        wait_done("R7 permuted");
        verify_run(64, "R7 count kept");
        cmp_mem("R8 permuted memory");
        chk(cap_d[63] != 32'hDEADDEAD, "R2 load during run", 64'(cap_d[63]), 64'(exp_data[63]));

        // R8: repeated addresses, later value survives
        clear_mem();
        load(0, 7'd0, 32'h000000AA, 1'b1);
        load(1, 7'd7, 32'h000000BB, 1'b1);
        load(2, 7'd0, 32'h000000CC, 1'b1);
        load(3, 7'd7, 32'h000000DD, 1'b1);
        want[0] = 32'hCC; want[7] = 32'hDD;
        kick(4);
        wait_done("R8 overwrite");
        verify_run(4, "R8 overwrite count");
        cmp_mem("R8 overwrite memory");

        // R6: zero count finishes at once
        throttle = 0;
        kick(0);
        chk(done == 1'b1, "R6 zero count done", 64'(done), 64'd1);
        chk(n_cmd == 0 && n_wd == 0, "R6 zero count transfers", 64'(n_cmd + n_wd), 64'd0);

        // R6: oversize count clamps to depth
        kick(100);
        wait_done("R6 clamp");
        chk(n_cmd == 64, "R6 clamp count", 64'(n_cmd), 64'd64);

        // R9: 64-bit word index 5 -> byte 0x28
        @(negedge clk);
        l64_en = 1'b1; l64_idx = 3'd0; l64_addr = 4'd5; l64_data = 64'h0DDF00DBADC0FFEE;
        @(negedge clk);
        l64_en = 1'b0; c64 = 4'd1; s64 = 1'b1;
        @(negedge clk);
        s64 = 1'b0;
        chk(v64c && a64 == 7'h28, "R9 byte offset", 64'(a64), 64'h28);
        chk(v64d && w64 == 64'h0DDF00DBADC0FFEE, "R9 data", w64, 64'h0DDF00DBADC0FFEE);
        @(negedge clk);
        chk(d64 == 1'b1, "R9 done", 64'(d64), 64'd1);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule